// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single transfer requests from an 8-bit core into external bus cycles on a bus where the low address byte and the data take turns on one set of wires. Each transfer starts with an address clock. In that clock the latch strobe is high and the shared bus carries the low address byte. One or more data clocks follow, with the active-low read or write strobe asserted. The high address byte, the memory/IO select and a two-bit status code stay steady for the whole cycle.

A peripheral can stretch any transfer by holding the ready input low. A halt request parks the bus in high impedance with status 00. An external float request releases the bus once the cycle in progress is finished. Read data comes back to the core with a single-clock done pulse.

Top module: `mbus_seq`

## Requirements
- R1: After reset, `ale` and `done` are 0, `rd_n` and `wr_n` are 1, `bus_oe` is 1, `ad_oe` is 0 and `req_ready` is 1.
- R2: In the first clock of a transfer, `ale` is 1 for exactly that one clock. In the same clock `ad_oe` is 1, `ad_out` carries address bits 7:0 and `addr_hi` carries address bits 15:8.
- R3: `stat` carries the cycle type for the whole transfer: 00 halt, 01 write, 10 read, 11 opcode fetch. `io_m` (1 = I/O, 0 = memory) and `addr_hi` also hold steady from the address clock to the last data clock.
- R4: In a read or fetch, `rd_n` is low from the second clock through the last clock of the cycle. During that time `ad_oe` is 0 and `wr_n` stays 1. The two strobes are never low together.
- R5: In a write, `wr_n` is low from the second clock through the last clock, with `rd_n` high. `ad_oe` is 1 and `ad_out` carries the write data in every clock where `wr_n` is low, including the last one.
- R6: `bus_ready` is sampled on each rising edge that ends the second clock or a wait clock. Each low sample adds one wait clock. The transfer is therefore 3 + W clocks long, where W is the number of low samples, and `done` rises in the clock after the final one.
- R7: `rdata` holds the value that was on `ad_in` at the edge ending the final data clock. `done` is high for exactly one clock per read, fetch or write.
- R8: An accepted halt request (kind 00) sets `stat` to 00, drives `bus_oe`, `ad_oe` and `ale` to 0, and gives no `done`. The bus stays in this state until a transfer request is accepted.
- R9: `float_req` takes effect only between transfers. When it is high while the block is idle or halted, the next clock has `bus_oe` and `ad_oe` at 0, no `ale`, and `req_ready` at 0. It wins over a request presented in the same clock. A transfer already in progress completes before the bus is released.
- R10: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when the block is idle or halted with no float request. The address clock of an accepted transfer follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | Cycle type: 00 halt, 01 write, 10 read, 11 fetch |
| req_addr | input | 16 | Transfer address |
| req_io | input | 1 | 1 selects I/O space, 0 memory |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request |
| float_req | input | 1 | External request to release the bus |
| bus_ready | input | 1 | Peripheral ready, low inserts wait clocks |
| ad_in | input | 8 | Value seen on the shared bus pins |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared bus |
| ad_oe | output | 1 | Output enable of the shared bus |
| bus_oe | output | 1 | Output enable of addr_hi, rd_n, wr_n and io_m |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | I/O or memory select for the cycle |
| stat | output | 2 | Cycle type status |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
Two functions can fall in the same clock: an external float request and the acceptance of a new core request. The bench raises `float_req` and `req_valid` on the same edge while the block is idle. It then checks that the bus floats with no latch strobe, and that the pending transfer runs with the right address, status and data only after the float is dropped. A second case raises the float request inside a write that is stretched by wait clocks. There the bench checks that the write finishes with its data and its done pulse before the bus is released.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // cycle type, value equals the status code on the pins
  typedef enum logic [1:0] {
    K_HALT  = 2'b00,
    K_WRITE = 2'b01,
    K_READ  = 2'b10,
    K_FETCH = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    P_IDLE,
    P_ADDR,
    P_DATA,
    P_WAIT,
    P_LAST,
    P_HALT,
    P_FLOAT
  } phase_e;

  function automatic logic kind_reads(kind_e k);
    return (k == K_READ) || (k == K_FETCH);
  endfunction

  function automatic logic kind_writes(kind_e k);
    return k == K_WRITE;
  endfunction

  function automatic logic phase_strobe(phase_e p);
    return (p == P_DATA) || (p == P_WAIT) || (p == P_LAST);
  endfunction

  function automatic logic phase_owns_bus(phase_e p);
    return (p != P_HALT) && (p != P_FLOAT);
  endfunction

  function automatic logic phase_accepts(phase_e p);
    return (p == P_IDLE) || (p == P_HALT);
  endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  kind_e             req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              float_req,
  input  logic              bus_ready,
  output logic              req_ready,
  output logic              accept_evt,
  output logic              float_evt,
  output phase_e            phase,
  output kind_e             cur_kind,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_io,
  output logic [DATA_W-1:0] cur_wdata
);

  phase_e phase_nx;

  assign req_ready  = phase_accepts(phase) && !float_req;
  assign accept_evt = req_valid && req_ready;
  assign float_evt  = phase_accepts(phase) && float_req;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      P_IDLE, P_HALT: begin
        if (float_req)       phase_nx = P_FLOAT;
        else if (req_valid)  phase_nx = (req_kind == K_HALT) ? P_HALT : P_ADDR;
      end
      P_ADDR:         phase_nx = P_DATA;
      P_DATA, P_WAIT: phase_nx = bus_ready ? P_LAST : P_WAIT;
      P_LAST:         phase_nx = P_IDLE;
      P_FLOAT:        phase_nx = float_req ? P_FLOAT : P_IDLE;
      default:        phase_nx = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      cur_kind  <= K_HALT;
      cur_addr  <= '0;
      cur_io    <= 1'b0;
      cur_wdata <= '0;
    end else begin
      phase <= phase_nx;
      if (accept_evt) begin
        cur_kind  <= req_kind;
        cur_addr  <= req_addr;
        cur_io    <= req_io;
        cur_wdata <= req_wdata;
      end
    end
  end

  // R6
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == P_DATA) || (phase == P_WAIT)) && !bus_ready |=> (phase == P_WAIT));

  // R9
  float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_FLOAT) && float_req |-> !req_ready);

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  kind_e             cur_kind,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_io,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              bus_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic [1:0]        stat
);

  logic addr_slot;
  logic strobe_slot;

  assign addr_slot   = (phase == P_ADDR);
  assign strobe_slot = phase_strobe(phase);

  assign ale     = addr_slot;
  assign bus_oe  = phase_owns_bus(phase);
  assign ad_oe   = addr_slot || (strobe_slot && kind_writes(cur_kind));
  assign ad_out  = addr_slot ? cur_addr[DATA_W-1:0] : cur_wdata;
  assign addr_hi = cur_addr[ADDR_W-1:DATA_W];
  assign rd_n    = !(strobe_slot && kind_reads(cur_kind));
  assign wr_n    = !(strobe_slot && kind_writes(cur_kind));
  assign io_m    = cur_io;
  assign stat    = cur_kind;

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe && bus_oe);

  // R3
  stat_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(stat) && $stable(io_m) && $stable(addr_hi));

endmodule

// File: rtl/mbus_rdcap.sv
module mbus_rdcap
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  logic end_evt;
  assign end_evt = (phase == P_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= end_evt;
      if (end_evt) rdata <= ad_in;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              float_req,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              bus_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic [1:0]        stat,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  phase_e              phase_w;
  kind_e               kind_w;
  logic [ADDR_W-1:0]   addr_w;
  logic                io_w;
  logic [DATA_W-1:0]   wdata_w;
  logic                accept_evt;
  logic                float_evt;

  mbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (kind_e'(req_kind)),
    .req_addr   (req_addr),
    .req_io     (req_io),
    .req_wdata  (req_wdata),
    .float_req  (float_req),
    .bus_ready  (bus_ready),
    .req_ready  (req_ready),
    .accept_evt (accept_evt),
    .float_evt  (float_evt),
    .phase      (phase_w),
    .cur_kind   (kind_w),
    .cur_addr   (addr_w),
    .cur_io     (io_w),
    .cur_wdata  (wdata_w)
  );

  mbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_w),
    .cur_kind  (kind_w),
    .cur_addr  (addr_w),
    .cur_io    (io_w),
    .cur_wdata (wdata_w),
    .addr_hi   (addr_hi),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .bus_oe    (bus_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .stat      (stat)
  );

  mbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase_w),
    .ad_in (ad_in),
    .rdata (rdata),
    .done  (done)
  );

  // R10
  accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && (req_kind != 2'b00) |=> ale && (ad_out == $past(req_addr[DATA_W-1:0])));

  // R8
  halt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && (req_kind == 2'b00) |=> !bus_oe && !ad_oe && !ale && (stat == 2'b00));

  // R9
  float_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    float_evt |=> !bus_oe && !ad_oe && !ale);

endmodule

// File: tb/mbus_seq_test.sv
module mbus_seq_test;

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        io;
    logic [7:0]  wdata;
    int          waits;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        float_req = 1'b0;
  logic        bus_ready = 1'b1;
  logic [7:0]  ad_in;
  logic [7:0]  addr_hi;
  logic [7:0]  ad_out;
  logic        ad_oe, bus_oe, ale, rd_n, wr_n, io_m, done;
  logic [1:0]  stat;
  logic [7:0]  rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  mbus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_io(req_io), .req_wdata(req_wdata),
    .req_ready(req_ready), .float_req(float_req), .bus_ready(bus_ready),
    .ad_in(ad_in), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .stat(stat), .rdata(rdata), .done(done)
  );

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slow peripheral: latches the address, holds ready low for waits_cfg clocks
  int          waits_cfg = 0;
  int          wcnt = 0;
  logic [15:0] mlat = '0;
  assign ad_in = !rd_n ? mem_val(mlat) : 8'h00;

  always @(negedge clk) begin
    if (ale) begin
      mlat      <= {addr_hi, ad_out};
      wcnt      <= waits_cfg;
      bus_ready <= 1'b1;
    end else if (!rd_n || !wr_n) begin
      bus_ready <= (wcnt == 0);
      if (wcnt > 0) wcnt <= wcnt - 1;
    end
  end

  // monitor and scoreboard
  int          len = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [15:0] seen_addr = '0;
  logic [1:0]  seen_stat = '0;
  logic        seen_io = 0;
  logic        seen_oe = 0;
  logic [7:0]  wseen = '0;
  bit          steady_bad = 0;
  bit          rd_oe_bad = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!rd_n && !wr_n) chk(0, "R4 strobes overlap", {rd_n, wr_n}, 2'b11);
      if (ale) begin
        seen_addr = {addr_hi, ad_out};
        seen_stat = stat;
        seen_io   = io_m;
        seen_oe   = ad_oe;
        len = 0; rd_cnt = 0; wr_cnt = 0;
        steady_bad = 0; rd_oe_bad = 0;
      end else begin
        len++;
      end
      if (!rd_n) begin rd_cnt++; if (ad_oe) rd_oe_bad = 1; end
      if (!wr_n) begin wr_cnt++; if (ad_oe) wseen = ad_out; end
      if ((!rd_n || !wr_n) && (stat != seen_stat || io_m != seen_io || addr_hi != seen_addr[15:8]))
        steady_bad = 1;
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected done", 1, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(seen_addr == e.addr, "R2 latched address", seen_addr, e.addr);
          chk(seen_oe, "R2 bus driven in address clock", seen_oe, 1);
          chk(seen_stat == e.kind, "R3 status code", seen_stat, e.kind);
          chk(seen_io == e.io, "R3 io_m", seen_io, e.io);
          chk(!steady_bad, "R3 held through cycle", steady_bad, 0);
          chk(len == 3 + e.waits, "R6 cycle length", len, 3 + e.waits);
          if (e.kind == 2'b01) begin
            chk(wr_cnt == 2 + e.waits && rd_cnt == 0, "R5 wr_n span", wr_cnt, 2 + e.waits);
            chk(wseen == e.wdata, "R5 write data at last clock", wseen, e.wdata);
          end else begin
            chk(rd_cnt == 2 + e.waits && wr_cnt == 0, "R4 rd_n span", rd_cnt, 2 + e.waits);
            chk(!rd_oe_bad, "R4 bus released while reading", rd_oe_bad, 0);
            chk(rdata == mem_val(e.addr), "R7 read data", rdata, mem_val(e.addr));
          end
        end
      end
    end
  end

  task automatic do_cycle(input logic [1:0] k, input logic [15:0] a, input logic io,
                          input logic [7:0] d, input int w);
    item_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    waits_cfg = w;
    req_kind = k; req_addr = a; req_io = io; req_wdata = d; req_valid = 1'b1;
    e.kind = k; e.addr = a; e.io = io; e.wdata = d; e.waits = w;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ale == 1'b1, "R10 address clock follows accept", ale, 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && exp_q.size() > 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all cycles completed", exp_q.size(), 0);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ale && !done, "R1 ale/done low", {ale, done}, 0);
    chk(rd_n && wr_n, "R1 strobes high", {rd_n, wr_n}, 2'b11);
    chk(bus_oe && !ad_oe, "R1 enables", {bus_oe, ad_oe}, 2'b10);
    chk(req_ready, "R1 req_ready", req_ready, 1);
    rst_n = 1'b1;

    // main patterns, back to back
    do_cycle(2'b11, 16'h1234, 1'b0, 8'h00, 0);
    do_cycle(2'b10, 16'hABCD, 1'b1, 8'h00, 2);
    do_cycle(2'b01, 16'h00FF, 1'b0, 8'hA5, 0);
    do_cycle(2'b01, 16'h7E81, 1'b1, 8'h3C, 3);
    do_cycle(2'b10, 16'hFF00, 1'b0, 8'h00, 5);
    do_cycle(2'b11, 16'h8001, 1'b0, 8'h00, 1);
    drain();

    // R8 halt
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = 2'b00; req_addr = 16'h4444; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!bus_oe && !ad_oe && !ale, "R8 halt floats bus", {bus_oe, ad_oe, ale}, 0);
      chk(stat == 2'b00 && !done, "R8 halt status", stat, 0);
      chk(req_ready, "R10 ready in halt", req_ready, 1);
      @(negedge clk);
    end
    do_cycle(2'b10, 16'h2468, 1'b0, 8'h00, 1);
    drain();

    // R9 float and request in the same clock
    @(negedge clk);
    float_req = 1'b1;
    req_kind = 2'b10; req_addr = 16'h5566; req_io = 1'b1; req_valid = 1'b1; waits_cfg = 0;
    begin
      item_t e;
      e.kind = 2'b10; e.addr = 16'h5566; e.io = 1'b1; e.wdata = 8'h00; e.waits = 0;
      exp_q.push_back(e);
    end
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(!bus_oe && !ad_oe && !ale, "R9 float wins over request", {bus_oe, ad_oe, ale}, 0);
      chk(!req_ready, "R9 ready low while floated", req_ready, 0);
      @(negedge clk);
    end
    float_req = 1'b0;
    for (int i = 0; i < 10 && !ale; i++) @(negedge clk);
    req_valid = 1'b0;
    drain();

    // R9 float raised inside a stretched write
    do_cycle(2'b01, 16'h0C0D, 1'b0, 8'h96, 3);
    while (wr_n) @(negedge clk);
    float_req = 1'b1;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    chk(done && bus_oe, "R9 cycle completes before release", {done, bus_oe}, 2'b11);
    @(negedge clk);
    chk(!bus_oe && !req_ready, "R9 released after cycle", {bus_oe, req_ready}, 0);
    float_req = 1'b0;
    do_cycle(2'b11, 16'hFFFF, 1'b1, 8'h00, 0);
    drain();

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule